// File: doc/BRIEF.md
# Programmable Third-Order Decimation Filter

This block turns a one-bit oversampled stream from a sigma-delta modulator into signed multi-bit words. Each accepted bit is mapped to +1 or -1 and passes through three cascaded integrators running at the sample rate. At every decimation boundary the last integrator is sampled into three cascaded differentiators, which gives a third-order sinc low-pass response. A strobe marks each sample, and the clock can run much faster than the sample rate.

The decimation ratio is eight times a programmable 8-bit rate word. A word below the legal minimum is raised to that minimum. The minimum is 3 in plain mode and 13 in chop mode. Chop mode adds a stage that averages three consecutive filter results into one output word, so it delivers a third as many words. A new word or mode is adopted only at a decimation boundary. The words that follow reset or a configuration change carry a flag until the filter history reflects only the new settings.

Top module: `sinc3_decim`

## Requirements
- R1: The response to a constant input is exact. A settled output equals +L³ when every input bit is 1 and -L³ when every bit is 0, where L is the decimation ratio.
- R2: With chop mode off, the output produced after input sample n is the sum of w(j)·x(n-j) for j from 0 to 3L-3. Here x is +1 for a 1 bit and -1 for a 0 bit, samples before reset count as 0, and w(j) is the number of ways to write j as a+b+c with each of a, b and c in 0..L-1.
- R3: L is 8 times the effective rate word. Only clock cycles with `samp_en` high count as samples. With chop off, a word appears after every L accepted samples, the first after sample L counted from reset.
- R4: With chop off, a rate word of 0, 1 or 2 acts as 3, so L is 24.
- R5: With chop on, any rate word below 13 acts as 13, so L is 104.
- R6: With chop on, one word appears per 3L samples. It is the sum of the three sinc results at samples 3kL+L-1, 3kL+2L-1 and 3kL+3L-1, divided by 3 and rounded toward zero.
- R7: A change of `rate_word` or `chop_mode` takes effect at the next decimation boundary. The period in progress completes at the old length, and the periods after it have the new length.
- R8: The first three filter results after reset, and after any change of the effective configuration, are flagged with `dout_unsettled` = 1. A chop-mode word is flagged if any of its three results is flagged. Writing a different word that clamps to the same effective value is not a change.
- R9: Reset clears `dout` to 0 and `dout_valid` to 0. `dout_valid` is a single-cycle pulse two clock cycles after the edge that accepts the boundary sample, and `dout` holds its value between pulses.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_en | input | 1 | Sample strobe; one modulator bit is accepted when high |
| samp_bit | input | 1 | Modulator output bit (1 = +1, 0 = -1) |
| rate_word | input | 8 | Decimation word; ratio is 8 times the clamped value |
| chop_mode | input | 1 | Enables the three-result averaging stage and its higher minimum word |
| dout | output | 35 | Signed two's-complement filter output |
| dout_valid | output | 1 | One-cycle strobe when `dout` is updated |
| dout_unsettled | output | 1 | Set when the current `dout` is built from incomplete history |

## Verification
The sweeps compare every output word against a direct weighted sum of the stored input bits, using a kernel the bench builds by counting. An integrator or differentiator that is missing, misordered or wraps too early would therefore give wrong values under the pseudo-random and periodic patterns, not only under constant ones. Rate words 0 to 2 and chop words below 13 are exercised; a missing clamp would show as outputs spaced by the wrong number of samples. One test changes the word in mid-period. Applying the change at once would shorten the current period, and failing to restart the settle count would leave the first words after the change unflagged. A second test writes a new word that clamps to the same effective value; a design that compares raw words would flag that as a change.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;

    localparam int SF_W       = 8;                // rate word width
    localparam int DEC_SHIFT  = 3;                // ratio = word << DEC_SHIFT
    localparam int CNT_W      = SF_W + DEC_SHIFT; // sample counter width
    localparam int ORDER      = 3;                // integrator/differentiator pairs
    localparam int ACC_W      = 35;               // enough for (8*255)^3 signed
    localparam int MIN_PLAIN  = 3;
    localparam int MIN_CHOP   = 13;
    localparam int SETTLE_N   = 3;                // flagged results after a change
    localparam int CHOP_GROUP = 3;                // results per chop-mode word

    typedef struct packed {
        logic            chop;
        logic [SF_W-1:0] word;
    } cfg_t;

    typedef struct packed {
        logic chop;
        logic unsettled;
        logic restart;
    } tag_t;

    localparam int TAG_W = $bits(tag_t);

    function automatic cfg_t clamp_cfg(input logic [SF_W-1:0] w, input logic c);
        cfg_t r;
        r.chop = c;
        if (c && (w < SF_W'(MIN_CHOP)))
            r.word = SF_W'(MIN_CHOP);
        else if (w < SF_W'(MIN_PLAIN))
            r.word = SF_W'(MIN_PLAIN);
        else
            r.word = w;
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] period_of(input cfg_t c);
        return CNT_W'(c.word) << DEC_SHIFT;
    endfunction

endpackage

// File: rtl/sinc3_integ.sv
module sinc3_integ #(
    parameter int ORDER = 3,
    parameter int W     = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] last_o
);

    typedef struct packed {
        logic [ORDER-1:0][W-1:0] acc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [W-1:0] carry;
        st_d  = st_q;
        carry = bit_i ? W'(1) : {W{1'b1}};
        if (en_i) begin
            for (int k = 0; k < ORDER; k++) begin
                st_d.acc[k] = st_q.acc[k] + carry;
                carry       = st_d.acc[k];
            end
        end
        last_o = st_d.acc[ORDER-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sinc3_rate.sv
module sinc3_rate
    import sinc3_pkg::*;
#(
    parameter int SETTLE = SETTLE_N
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [SF_W-1:0] word_i,
    input  logic            chop_i,
    output logic            boundary_o,
    output cfg_t            cfg_o,
    output tag_t            tag_o
);

    localparam int SET_W = $clog2(SETTLE + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        cfg_t             act;
        logic [SET_W-1:0] settle;
        logic             restart;
    } st_t;

    st_t  st_d, st_q;
    cfg_t req_cfg;

    always_comb begin
        st_d       = st_q;
        req_cfg    = clamp_cfg(word_i, chop_i);
        boundary_o = 1'b0;
        if (en_i) begin
            if (st_q.cnt == '0) begin
                // first sample after reset opens the first period
                st_d.cnt     = period_of(req_cfg) - CNT_W'(1);
                st_d.act     = req_cfg;
                st_d.settle  = SET_W'(SETTLE);
                st_d.restart = 1'b1;
            end else if (st_q.cnt == CNT_W'(1)) begin
                boundary_o   = 1'b1;
                st_d.cnt     = period_of(req_cfg);
                if (req_cfg != st_q.act) begin
                    st_d.act     = req_cfg;
                    st_d.settle  = SET_W'(SETTLE);
                    st_d.restart = 1'b1;
                end else begin
                    st_d.restart = 1'b0;
                    if (st_q.settle != '0)
                        st_d.settle = st_q.settle - SET_W'(1);
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        cfg_o           = st_q.act;
        tag_o.chop      = st_q.act.chop;
        tag_o.unsettled = (st_q.settle != '0);
        tag_o.restart   = st_q.restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sinc3_comb.sv
module sinc3_comb #(
    parameter int ORDER = 3,
    parameter int W     = 35,
    parameter int TW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [W-1:0]  sample_i,
    input  logic [TW-1:0] tag_i,
    output logic [W-1:0]  res_o,
    output logic [TW-1:0] tag_o,
    output logic          valid_o
);

    typedef struct packed {
        logic [ORDER-1:0][W-1:0] dly;
        logic [W-1:0]            res;
        logic [TW-1:0]           tag;
        logic                    valid;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic [W-1:0] v;
        logic [W-1:0] diff;
        st_d       = st_q;
        st_d.valid = 1'b0;
        v          = sample_i;
        diff       = '0;
        if (take_i) begin
            for (int k = 0; k < ORDER; k++) begin
                diff        = v - st_q.dly[k];
                st_d.dly[k] = v;
                v           = diff;
            end
            st_d.res   = v;
            st_d.tag   = tag_i;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_o   = st_q.res;
    assign tag_o   = st_q.tag;
    assign valid_o = st_q.valid;

endmodule

// File: rtl/sinc3_chop_avg.sv
module sinc3_chop_avg #(
    parameter int W     = 35,
    parameter int GROUP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic [W-1:0] value_i,
    input  logic         chop_i,
    input  logic         unsettled_i,
    input  logic         restart_i,
    output logic [W-1:0] value_o,
    output logic         valid_o,
    output logic         unsettled_o
);

    localparam int SW   = W + $clog2(GROUP) + 1;
    localparam int PH_W = $clog2(GROUP);
    localparam logic signed [SW-1:0] GROUP_S = SW'(GROUP);

    typedef struct packed {
        logic [SW-1:0]   sum;
        logic [PH_W-1:0] phase;
        logic            dirty;
        logic [W-1:0]    out;
        logic            oflag;
        logic            ovalid;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        logic signed [SW-1:0] ext;
        logic signed [SW-1:0] s;
        logic signed [SW-1:0] q;
        logic [PH_W-1:0]      ph;
        logic                 d;
        st_d        = st_q;
        st_d.ovalid = 1'b0;
        ext = $signed({{(SW-W){value_i[W-1]}}, value_i});
        s   = '0;
        q   = '0;
        ph  = '0;
        d   = 1'b0;
        if (valid_i) begin
            if (!chop_i) begin
                st_d.out    = value_i;
                st_d.oflag  = unsettled_i;
                st_d.ovalid = 1'b1;
                st_d.sum    = '0;
                st_d.phase  = '0;
                st_d.dirty  = 1'b0;
            end else begin
                ph = restart_i ? '0 : st_q.phase;
                s  = (ph == '0) ? ext : ($signed(st_q.sum) + ext);
                d  = ((ph == '0) ? 1'b0 : st_q.dirty) | unsettled_i;
                if (ph == PH_W'(GROUP - 1)) begin
                    q           = s / GROUP_S;
                    st_d.out    = q[W-1:0];
                    st_d.oflag  = d;
                    st_d.ovalid = 1'b1;
                    st_d.sum    = '0;
                    st_d.phase  = '0;
                    st_d.dirty  = 1'b0;
                end else begin
                    st_d.sum   = s;
                    st_d.phase = ph + PH_W'(1);
                    st_d.dirty = d;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value_o     = st_q.out;
    assign valid_o     = st_q.ovalid;
    assign unsettled_o = st_q.oflag;

endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import sinc3_pkg::*;
#(
    parameter int OUT_W = ACC_W,
    parameter int STAGES = ORDER
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_en,
    input  logic             samp_bit,
    input  logic [SF_W-1:0]  rate_word,
    input  logic             chop_mode,
    output logic [OUT_W-1:0] dout,
    output logic             dout_valid,
    output logic             dout_unsettled
);

    logic [OUT_W-1:0] int_last;
    logic             boundary;
    cfg_t             act_cfg;
    tag_t             bnd_tag;
    logic [TAG_W-1:0] res_tag_v;
    tag_t             res_tag;
    logic [OUT_W-1:0] res_val;
    logic             res_valid;

    sinc3_integ #(.ORDER(STAGES), .W(OUT_W)) u_integ (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (samp_en),
        .bit_i  (samp_bit),
        .last_o (int_last)
    );

    sinc3_rate #(.SETTLE(SETTLE_N)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (samp_en),
        .word_i     (rate_word),
        .chop_i     (chop_mode),
        .boundary_o (boundary),
        .cfg_o      (act_cfg),
        .tag_o      (bnd_tag)
    );

    sinc3_comb #(.ORDER(STAGES), .W(OUT_W), .TW(TAG_W)) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (boundary),
        .sample_i (int_last),
        .tag_i    (bnd_tag),
        .res_o    (res_val),
        .tag_o    (res_tag_v),
        .valid_o  (res_valid)
    );

    assign res_tag = tag_t'(res_tag_v);

    sinc3_chop_avg #(.W(OUT_W), .GROUP(CHOP_GROUP)) u_avg (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (res_valid),
        .value_i     (res_val),
        .chop_i      (res_tag.chop),
        .unsettled_i (res_tag.unsettled),
        .restart_i   (res_tag.restart),
        .value_o     (dout),
        .valid_o     (dout_valid),
        .unsettled_o (dout_unsettled)
    );

endmodule

// File: rtl/sinc3_decim_chk.sv
module sinc3_decim_chk
    import sinc3_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            samp_en,
    input logic            dout_valid,
    input logic            dout_unsettled,
    input logic            boundary,
    input logic            res_valid,
    input logic [SF_W-1:0] act_word,
    input logic            act_chop
);

    logic     seen_q;
    logic     got_q;
    int       since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            got_q   <= 1'b0;
            since_q <= 0;
        end else begin
            if (samp_en) begin
                seen_q  <= 1'b1;
                since_q <= boundary ? 0 : since_q + 1;
            end
            if (dout_valid) got_q <= 1'b1;
        end
    end

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |=> !dout_valid);

    // R9
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> $past(res_valid));

    // R3
    boundary_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |-> samp_en);

    // R3
    min_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |-> (since_q >= (MIN_PLAIN << DEC_SHIFT) - 1));

    // R4
    plain_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (act_word >= SF_W'(MIN_PLAIN)));

    // R5
    chop_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && act_chop) |-> (act_word >= SF_W'(MIN_CHOP)));

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seen_q) && !$past(boundary)) |-> ($stable(act_word) && $stable(act_chop)));

    // R8
    first_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !got_q) |-> dout_unsettled);

endmodule

bind sinc3_decim sinc3_decim_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .samp_en        (samp_en),
    .dout_valid     (dout_valid),
    .dout_unsettled (dout_unsettled),
    .boundary       (boundary),
    .res_valid      (res_valid),
    .act_word       (act_cfg.word),
    .act_chop       (act_cfg.chop)
);

// File: tb/test_sinc3_decim.sv
module test_sinc3_decim;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        samp_en = 1'b0;
    logic        samp_bit = 1'b0;
    logic [7:0]  rate_word = 8'd3;
    logic        chop_mode = 1'b0;
    logic [34:0] dout;
    logic        dout_valid;
    logic        dout_unsettled;

    sinc3_decim i_sinc3_decim (
        .clk            (clk),
        .rst_n          (rst_n),
        .samp_en        (samp_en),
        .samp_bit       (samp_bit),
        .rate_word      (rate_word),
        .chop_mode      (chop_mode),
        .dout           (dout),
        .dout_valid     (dout_valid),
        .dout_unsettled (dout_unsettled)
    );

    always #10 clk = ~clk;

    int     nchk = 0;
    int     nerr = 0;
    bit     xs [0:4095];
    int     nsamp = 0;
    longint gv [0:63];
    bit     gu [0:63];
    int     ga [0:63];
    int     ng = 0;
    bit     prev_v = 0;
    bit     have_held = 0;
    bit     hold_bad = 0;
    bit     pulse_bad = 0;
    logic [34:0] held;
    bit     done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (dout_valid) begin
                if (ng < 64) begin
                    gv[ng] = longint'($signed(dout));
                    gu[ng] = dout_unsettled;
                    ga[ng] = nsamp;
                end
                ng++;
                if (prev_v) pulse_bad = 1;
                held = dout;
                have_held = 1;
            end else if (have_held && dout !== held) begin
                hold_bad = 1;
            end
            prev_v = dout_valid;
        end
    end

    function automatic bit pat_bit(input int p, input int i);
        int unsigned h;
        h = (i * 1103515245) + 12345;
        case (p)
            0: return 1'b1;
            1: return 1'b0;
            2: return i[0];
            3: return h[16];
            4: return (i % 4) == 0;
            default: return ((i / 7) % 2) == 1;
        endcase
    endfunction

    function automatic longint wcoef(input int j, input int L);
        longint c = 0;
        for (int a = 0; a < L; a++) begin
            int lo = j - a - (L - 1);
            int hi = j - a;
            if (lo < 0) lo = 0;
            if (hi > L - 1) hi = L - 1;
            if (hi >= lo) c += hi - lo + 1;
        end
        return c;
    endfunction

    function automatic longint ref_out(input int n, input int L);
        longint acc = 0;
        for (int j = 0; j <= 3 * L - 3; j++) begin
            if (n - j >= 0) acc += wcoef(j, L) * (xs[n - j] ? 64'sd1 : -64'sd1);
        end
        return acc;
    endfunction

    task automatic feed(input bit b, input int gap);
        @(negedge clk);
        xs[nsamp] = b;
        nsamp++;
        samp_en = 1'b1;
        samp_bit = b;
        @(negedge clk);
        samp_en = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_reset(input logic [7:0] w, input bit c);
        @(negedge clk);
        rst_n = 1'b0;
        samp_en = 1'b0;
        rate_word = w;
        chop_mode = c;
        repeat (3) @(negedge clk);
        ng = 0; nsamp = 0; prev_v = 0; have_held = 0; hold_bad = 0; pulse_bad = 0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_plain(input int w, input int p, input int nout, input int gap);
        int L = 8 * ((w < 3) ? 3 : w);
        do_reset(8'(w), 1'b0);
        for (int i = 0; i < nout * L; i++) feed(pat_bit(p, i), gap + (i % 2));
        repeat (4) @(negedge clk);
        chk(ng == nout, "R3 output count", ng, nout);
        for (int k = 0; k < nout && k < ng; k++) begin
            chk(ga[k] == (k + 1) * L, (w < 3) ? "R4 spacing" : "R3 spacing", ga[k], (k + 1) * L);
            chk(gu[k] == (k < 3), "R8 settle flag", gu[k], k < 3);
            chk(gv[k] == ref_out((k + 1) * L - 1, L), "R2 value", gv[k], ref_out((k + 1) * L - 1, L));
            if (k >= 3 && p == 0) chk(gv[k] == longint'(L) * L * L, "R1 ones", gv[k], longint'(L) * L * L);
            if (k >= 3 && p == 1) chk(gv[k] == -longint'(L) * L * L, "R1 zeros", gv[k], -longint'(L) * L * L);
        end
        chk(!hold_bad && !pulse_bad, "R9 pulse and hold", hold_bad, 0);
    endtask

    task automatic run_chop(input int w, input int p, input int nout);
        int L = 8 * ((w < 13) ? 13 : w);
        do_reset(8'(w), 1'b1);
        for (int i = 0; i < nout * 3 * L; i++) feed(pat_bit(p, i), 1);
        repeat (4) @(negedge clk);
        chk(ng == nout, "R6 output count", ng, nout);
        for (int k = 0; k < nout && k < ng; k++) begin
            longint e;
            e = (ref_out(3 * k * L + L - 1, L) + ref_out(3 * k * L + 2 * L - 1, L)
                 + ref_out(3 * k * L + 3 * L - 1, L)) / 3;
            chk(ga[k] == 3 * (k + 1) * L, (w < 13) ? "R5 spacing" : "R6 spacing", ga[k], 3 * (k + 1) * L);
            chk(gv[k] == e, "R6 average", gv[k], e);
            chk(gu[k] == (k == 0), "R8 chop flag", gu[k], k == 0);
        end
        chk(!hold_bad && !pulse_bad, "R9 pulse and hold", hold_bad, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(dout == '0, "R9 reset dout", longint'(dout), 0);
        chk(dout_valid == 1'b0, "R9 reset valid", dout_valid, 0);

        run_plain(0, 0, 5, 1);
        run_plain(1, 1, 5, 2);
        run_plain(2, 2, 5, 1);
        run_plain(3, 3, 6, 3);
        run_plain(4, 4, 5, 1);
        run_plain(5, 5, 5, 2);
        run_plain(9, 3, 4, 1);

        // R7 mid-period change from word 4 (L=32) to word 6 (L=48)
        do_reset(8'd4, 1'b0);
        for (int i = 0; i < 74; i++) feed(pat_bit(3, i), 1);
        rate_word = 8'd6;
        for (int i = 74; i < 336; i++) feed(pat_bit(3, i), 1);
        repeat (4) @(negedge clk);
        chk(ng == 8, "R7 output count", ng, 8);
        begin
            int expa [0:7] = '{32, 64, 96, 144, 192, 240, 288, 336};
            for (int k = 0; k < 8 && k < ng; k++) begin
                chk(ga[k] == expa[k], "R7 boundary", ga[k], expa[k]);
                chk(gu[k] == (k < 6), "R8 flag after change", gu[k], k < 6);
            end
            for (int k = 6; k < 8 && k < ng; k++)
                chk(gv[k] == ref_out(expa[k] - 1, 48), "R7 value after change", gv[k], ref_out(expa[k] - 1, 48));
        end

        // R8 new word clamping to the same effective value is not a change
        do_reset(8'd1, 1'b0);
        for (int i = 0; i < 40; i++) feed(pat_bit(5, i), 1);
        rate_word = 8'd2;
        for (int i = 40; i < 240; i++) feed(pat_bit(5, i), 1);
        repeat (4) @(negedge clk);
        chk(ng == 10, "R8 output count", ng, 10);
        for (int k = 0; k < 10 && k < ng; k++) begin
            chk(gu[k] == (k < 3), "R8 equal clamp no restart", gu[k], k < 3);
            chk(gv[k] == ref_out((k + 1) * 24 - 1, 24), "R4 value", gv[k], ref_out((k + 1) * 24 - 1, 24));
        end

        run_chop(5, 0, 3);
        run_chop(14, 3, 3);
        run_chop(0, 5, 2);

        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                nchk++;
                nerr++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule